// File: doc/BRIEF.md
# GPIO Controller with Interrupts

This peripheral provides sixteen general-purpose pins behind a small memory-mapped register bus with 16-bit data. Every register holds one bit per pin. Software picks each pin's direction. It changes output levels with write-one set and clear strobes, so it never needs a read-modify-write. It can read back both the driven output value and the synchronized pin level.

Each pin can request an interrupt in one of five ways: high level, low level, rising edge, falling edge or either edge. Four configuration vectors choose the trigger:

- level select
- level polarity
- rising-edge enable
- falling-edge enable

Edge events are latched as pending until software clears them. Level conditions are pending for as long as the level is present. A pin reaches the masked-status register only when its mask bit is clear and its enable bit is set. The single interrupt line is a registered OR of the masked status.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mask register (0x28) reads 0xFFFF, every other readable register reads 0, pin_oe and pin_out are 0 and irq is low.
- R2: The direction register (0x00) drives pin_oe bit for bit, with 1 meaning output. The direction, level select (0x04), polarity (0x08), rising enable (0x0C), falling enable (0x10), mask (0x28) and enable (0x2C) registers read back the last value written.
- R3: Writing the set register (0x18) drives the pin_out bits that are 1 high, and writing the clear register (0x1C) drives them low. Bits written as 0 leave their outputs unchanged. The output data register (0x20) reads pin_out.
- R4: Reading the input data register (0x14) returns pin_in through a two-flop synchronizer. A change on pin_in before clock edge k is readable after edge k+1 and not after edge k.
- R5: With its level select bit at 1, a pin is pending while its synchronized level equals its polarity bit (1 means active high, 0 means active low). Its edge enables are then ignored.
- R6: With level select at 0, a pin latches a pending bit on a synchronized 0-to-1 change when its rising enable is 1, and on a 1-to-0 change when its falling enable is 1. Both enables together give both edges.
- R7: The masked-status register (0x30) reads the pending bits ANDed with the enable bits (0x2C) and with the inverse of the mask bits. An edge pending bit latches even while the pin is masked.
- R8: Writing 1s to the clear register (0x34) clears the matching latched edge pending bits, and bits written as 0 are kept. A level condition that is still present shows again right after a clear.
- R9: irq is the OR of the masked-status bits, registered. For an active-high level pin that is unmasked and enabled, irq is low after the second clock edge following a pin change and high after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output values to the pads |
| pin_oe | output | 16 | Output enables, 1 = pin driven |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach from the ports involve timing between history and configuration. One is an edge event that was latched while its pin was masked and only becomes visible when the mask is later lifted. Another is a clear written while a level condition is still present. The random phase reaches both by interleaving pin changes with writes to the mask, enable, trigger and clear registers. A bench model tracks the last stable pin vector, so it knows which edges must have latched. Directed cases then force the masked-edge, level-reappearance and three-edge irq latency situations explicitly.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIR  = AW'('h00);
  localparam logic [AW-1:0] A_LVL  = AW'('h04);
  localparam logic [AW-1:0] A_POL  = AW'('h08);
  localparam logic [AW-1:0] A_RISE = AW'('h0C);
  localparam logic [AW-1:0] A_FALL = AW'('h10);
  localparam logic [AW-1:0] A_IN   = AW'('h14);
  localparam logic [AW-1:0] A_SET  = AW'('h18);
  localparam logic [AW-1:0] A_OCLR = AW'('h1C);
  localparam logic [AW-1:0] A_OUT  = AW'('h20);
  localparam logic [AW-1:0] A_MASK = AW'('h28);
  localparam logic [AW-1:0] A_EN   = AW'('h2C);
  localparam logic [AW-1:0] A_STAT = AW'('h30);
  localparam logic [AW-1:0] A_ICLR = AW'('h34);

  logic [W-1:0] dir_q, lvl_q, pol_q, rise_q, fall_q, dout_q, mask_q, en_q;
  logic [W-1:0] sync1_q, sync2_q, prev_q, edge_pend_q;
  logic [W-1:0] edge_evt, level_hit, status, clr_vec;

  assign clr_vec   = (bus_wr && bus_addr == A_ICLR) ? bus_wdata : '0;
  assign edge_evt  = ~lvl_q & ((rise_q & sync2_q & ~prev_q) | (fall_q & ~sync2_q & prev_q));
  assign level_hit = lvl_q & ~(sync2_q ^ pol_q);
  assign status    = (edge_pend_q | level_hit) & ~mask_q & en_q;
  assign pin_out   = dout_q;
  assign pin_oe    = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q       <= '0;
      lvl_q       <= '0;
      pol_q       <= '0;
      rise_q      <= '0;
      fall_q      <= '0;
      dout_q      <= '0;
      mask_q      <= '1;
      en_q        <= '0;
      sync1_q     <= '0;
      sync2_q     <= '0;
      prev_q      <= '0;
      edge_pend_q <= '0;
      irq         <= 1'b0;
    end else begin
      sync1_q     <= pin_in;
      sync2_q     <= sync1_q;
      prev_q      <= sync2_q;
      edge_pend_q <= (edge_pend_q & ~clr_vec) | edge_evt;
      irq         <= |status;
      if (bus_wr) begin
        case (bus_addr)
          A_DIR:   dir_q  <= bus_wdata;
          A_LVL:   lvl_q  <= bus_wdata;
          A_POL:   pol_q  <= bus_wdata;
          A_RISE:  rise_q <= bus_wdata;
          A_FALL:  fall_q <= bus_wdata;
          A_SET:   dout_q <= dout_q | bus_wdata;
          A_OCLR:  dout_q <= dout_q & ~bus_wdata;
          A_MASK:  mask_q <= bus_wdata;
          A_EN:    en_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_LVL:   bus_rdata = lvl_q;
      A_POL:   bus_rdata = pol_q;
      A_RISE:  bus_rdata = rise_q;
      A_FALL:  bus_rdata = fall_q;
      A_IN:    bus_rdata = sync2_q;
      A_OUT:   bus_rdata = dout_q;
      A_MASK:  bus_rdata = mask_q;
      A_EN:    bus_rdata = en_q;
      A_STAT:  bus_rdata = status;
      default: bus_rdata = '0;
    endcase
  end

  assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OCLR) |=> ((pin_out & $past(bus_wdata)) == '0));

  assert_full_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |=> !irq);

  assert_pending_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_pend_q & ~clr_vec)) |=> (($past(edge_pend_q & ~clr_vec) & ~edge_pend_q) == '0));

  assert_no_enable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq);
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_dir, m_lvl, m_pol, m_rise, m_fall, m_dout, m_mask, m_en, m_edge, m_pins;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  function automatic logic [15:0] exp_status();
    return (m_edge | (m_lvl & ~(m_pins ^ m_pol))) & ~m_mask & m_en;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      6'h00: m_dir = d;
      6'h04: m_lvl = d;
      6'h08: m_pol = d;
      6'h0C: m_rise = d;
      6'h10: m_fall = d;
      6'h18: m_dout = m_dout | d;
      6'h1C: m_dout = m_dout & ~d;
      6'h28: m_mask = d;
      6'h2C: m_en = d;
      6'h34: m_edge = m_edge & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic drive_pins(input logic [15:0] v);
    @(negedge clk);
    m_edge = m_edge | (~m_lvl & ((m_rise & v & ~m_pins) | (m_fall & ~v & m_pins)));
    m_pins = v;
    pin_in = v;
    idle(5);
  endtask

  task automatic check_irq_state(input string tag);
    logic [15:0] d;
    idle(2);
    rd(6'h30, d);
    chk(tag, d, exp_status());
    chk(tag, {15'd0, irq}, {15'd0, |exp_status()});
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    m_dir = 0; m_lvl = 0; m_pol = 0; m_rise = 0; m_fall = 0;
    m_dout = 0; m_mask = 16'hFFFF; m_en = 0; m_edge = 0; m_pins = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(6'h28, d); chk("R1 mask", d, 16'hFFFF);
    rd(6'h00, d); chk("R1 dir", d, 16'h0);
    rd(6'h20, d); chk("R1 dout", d, 16'h0);
    rd(6'h30, d); chk("R1 status", d, 16'h0);
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);

    // R2 direction
    wr(6'h00, 16'hA5C3);
    chk("R2 oe", pin_oe, 16'hA5C3);
    rd(6'h00, d); chk("R2 dir readback", d, 16'hA5C3);

    // R3 set/clear
    wr(6'h18, 16'h00F0);
    chk("R3 set", pin_out, 16'h00F0);
    wr(6'h18, 16'h0003);
    chk("R3 set keeps", pin_out, 16'h00F3);
    wr(6'h1C, 16'h0030);
    chk("R3 clear", pin_out, 16'h00C3);
    rd(6'h20, d); chk("R3 out readback", d, 16'h00C3);

    // R4 input synchronizer latency
    @(negedge clk); pin_in = 16'h1234;
    @(negedge clk); rd(6'h14, d); chk("R4 not yet", d, 16'h0000);
    @(negedge clk); rd(6'h14, d); chk("R4 visible", d, 16'h1234);
    m_pins = 16'h1234;
    drive_pins(16'h0000);

    // R9 latency with active-high level on pin 0
    wr(6'h04, 16'h0001); wr(6'h08, 16'h0001);
    wr(6'h2C, 16'h0001); wr(6'h28, 16'hFFFE);
    idle(2);
    @(negedge clk); pin_in = 16'h0001;
    @(negedge clk);
    @(negedge clk); chk("R9 low after two edges", {15'd0, irq}, 16'h0);
    @(negedge clk); chk("R9 high after three edges", {15'd0, irq}, 16'h1);
    m_pins = 16'h0001;
    idle(2);

    // R8 level reappears after clear
    wr(6'h34, 16'h0001);
    check_irq_state("R8 level reappears");
    // R5 active-low
    wr(6'h08, 16'h0000);
    check_irq_state("R5 active low idle");
    drive_pins(16'h0000);
    check_irq_state("R5 active low hit");
    // R5 edge enables ignored in level mode
    wr(6'h08, 16'h0001); wr(6'h0C, 16'h0001); wr(6'h10, 16'h0001);
    drive_pins(16'h0000);
    check_irq_state("R5 edges ignored");

    // R6 and R7: edge latched while masked, visible after unmask
    wr(6'h04, 16'h0000); wr(6'h28, 16'hFFFF); wr(6'h2C, 16'h0002);
    wr(6'h0C, 16'h0002); wr(6'h10, 16'h0000);
    drive_pins(16'h0002);
    check_irq_state("R7 masked edge hidden");
    wr(6'h28, 16'hFFFD);
    check_irq_state("R7 masked edge appears");
    drive_pins(16'h0000);
    wr(6'h34, 16'h0000);
    check_irq_state("R8 zero keeps pending");
    wr(6'h34, 16'h0002);
    check_irq_state("R8 clear edge");
    wr(6'h10, 16'h0002); wr(6'h0C, 16'h0000);
    drive_pins(16'h0002);
    check_irq_state("R6 falling ignores rise");
    drive_pins(16'h0000);
    check_irq_state("R6 falling edge");

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int act;
      logic [15:0] v;
      act = $urandom_range(0, 9);
      v = 16'($urandom);
      case (act)
        0: wr(6'h04, v & 16'($urandom));
        1: wr(6'h08, v);
        2: wr(6'h0C, v);
        3: wr(6'h10, v);
        4: wr(6'h28, v | 16'($urandom));
        5: wr(6'h2C, v);
        6: wr(6'h34, v);
        7: begin
          wr(6'h00, v);
          chk("R2 random oe", pin_oe, m_dir);
        end
        8: begin
          if (v[0]) wr(6'h18, 16'($urandom)); else wr(6'h1C, 16'($urandom));
          rd(6'h20, d); chk("R3 random out", d, m_dout);
        end
        default: drive_pins(v);
      endcase
      if (i % 4 == 0) check_irq_state("R6 R7 random status");
      if (i % 50 == 0) begin
        rd(6'h0C, d); chk("R2 rise readback", d, m_rise);
        rd(6'h2C, d); chk("R2 enable readback", d, m_en);
        rd(6'h14, d); chk("R4 random input", d, m_pins);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule